// File: doc/BRIEF.md
# Programmable Video Beam Position Counter

The block tracks where the electron beam sits on a raster display. It keeps a horizontal position that counts clocks within a line and a vertical position that counts lines within a frame. It also keeps two flags. One marks a long line and the other marks a long frame. Sync generation, blanking and display fetch elsewhere in the chip compare against these outputs.

Totals come from one of two sources. In fixed mode they are built in: a 60 Hz standard with 262/263-line frames whose lines alternate between 227 and 228 clocks, or a 50 Hz standard with 312/313-line frames of 227-clock lines. In programmed mode, software loads the line and frame totals through a small write port. A second, free-running horizontal counter with its own loadable total can take the place of the main horizontal count at the end-of-line comparator. This supports unusual dual-rate displays.

Top module: `beam_position_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `hpos`, `vpos`, `hpos_alt`, `long_line` and `long_frame` all become 0. The same reset returns the control word to 0 and the three totals to 226, 261 and 226.
- R2: With control bits prog=0 and pal=0 and no_alt=0 (the reset state), lines alternate between 227 and 228 clocks, starting with a 227-clock line after reset. A frame is 262 lines when `long_frame` is 0.
- R3: With prog=0 and pal=1 (control bit 0), every line is 227 clocks and a frame is 312 lines when `long_frame` is 0, so `vpos` peaks at 311.
- R4: Control bit 1 (no_alt), when set with pal=0, makes every line short (227 clocks in fixed mode) and holds `long_line` at 0.
- R5: With control bit 2 (prog) set, a line ends when the compared horizontal position equals the line total at address 1 plus `long_line`. A frame ends at the line where `vpos` equals the frame total at address 2 plus `long_frame`. The fixed totals play no part.
- R6: In programmed mode, a set pal bit also stops the alternation: every line is line total + 1 clocks and `long_line` stays 0.
- R7: Alternation is active exactly when pal=0 and no_alt=0. `long_line` then inverts at every line end. When alternation is inactive, `long_line` is 0 from the next clock.
- R8: At every frame end, `long_frame` inverts when control bit 4 (interlace) is set and becomes 0 when it is clear. Each frame with `long_frame`=1 has one extra line.
- R9: `hpos_alt` counts up by one every clock and wraps to 0 in the clock after it equals the secondary total at address 3, whatever the main counters do.
- R10: With control bit 3 (dual) set, the end-of-line comparison uses `hpos_alt` instead of `hpos`.
- R11: At a line end `hpos` returns to 0 and `vpos` steps by one, or returns to 0 at a frame end. At all other clocks `hpos` increments and `vpos` holds.
- R12: A write with `wr_en`=1 is stored at the clock edge. The counters first use the new value at the following edge. Address 0 holds the control word, and the totals use the low bits of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 line total, 2 frame total, 3 secondary total |
| wr_data | input | DW (9) | Write data |
| hpos | output | HW (9) | Main horizontal position |
| vpos | output | VW (9) | Vertical position |
| hpos_alt | output | HW (9) | Secondary horizontal position |
| long_line | output | 1 | Current line is a long line |
| long_frame | output | 1 | Current frame is a long frame |

## Verification
On every cycle, the bound checker confirms these stepping rules:
- both horizontal counters advance by one or return to 0;
- the vertical position moves only at a line start, and only by one or back to 0;
- `long_line` rises only at a line start and is cleared once alternation is off;
- `long_frame` changes only at the frame origin.

The actual totals cannot be checked on every cycle. The bench's scenarios show them: the 227/228 rhythm, the 262- and 312-line frames, the programmed totals, the effect of the pal and no_alt bits on alternation, interlace frame lengths and the dual-source line end. The bench measures line lengths and frame heights at the ports and compares every output each cycle against an arithmetic model, over a sweep of small programmed totals.

// File: rtl/beam_pkg.sv
// Shared types for the beam position counter.
// Assumes a 2-bit register address and a 5-bit control word.
package beam_pkg;

    // Control word; packed MSB first, so pal lands on bit 0 of the write data.
    typedef struct packed {
        logic interlace;   // bit 4
        logic dual;        // bit 3
        logic prog;        // bit 2
        logic no_alt;      // bit 1
        logic pal;         // bit 0
    } beam_ctrl_t;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        ADDR_CTRL    = 2'd0,
        ADDR_H_LAST  = 2'd1,
        ADDR_V_LAST  = 2'd2,
        ADDR_H2_LAST = 2'd3
    } beam_addr_e;

endpackage

// File: rtl/beam_regs.sv
// Register file for the beam position counter: control word and three totals.
// Assumes DW >= CTRL_W, HW and VW; upper write bits beyond a field are dropped.
module beam_regs
    import beam_pkg::*;
#(
    parameter int HW = 9,
    parameter int VW = 9,
    parameter int DW = 9,
    parameter int RST_H_LAST  = 226,
    parameter int RST_V_LAST  = 261,
    parameter int RST_H2_LAST = 226
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output beam_ctrl_t    ctrl,
    output logic [HW-1:0] h_last_reg,
    output logic [VW-1:0] v_last_reg,
    output logic [HW-1:0] h2_last_reg
);

    // Store a write into the addressed register, or restore defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl        <= '0;
            h_last_reg  <= HW'(RST_H_LAST);
            v_last_reg  <= VW'(RST_V_LAST);
            h2_last_reg <= HW'(RST_H2_LAST);
        end else if (wr_en) begin
            unique case (beam_addr_e'(wr_addr))
                ADDR_CTRL:    ctrl        <= beam_ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_H_LAST:  h_last_reg  <= wr_data[HW-1:0];
                ADDR_V_LAST:  v_last_reg  <= wr_data[VW-1:0];
                ADDR_H2_LAST: h2_last_reg <= wr_data[HW-1:0];
            endcase
        end
    end

endmodule

// File: rtl/beam_wrap_counter.sv
// Up-counter that returns to zero on a wrap request.
// Assumes the caller decides when to wrap; otherwise it rolls over at 2**W.
module beam_wrap_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wrap,
    output logic [W-1:0] cnt
);

    // Advance by one each clock or restart at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/beam_vertical.sv
// Vertical position and long-frame flag, stepped once per line end.
// Assumes frame_last already includes the extra line of a long frame.
module beam_vertical #(
    parameter int VW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [VW-1:0] frame_last,
    input  logic          interlace,
    output logic [VW-1:0] vpos,
    output logic          long_frame
);

    logic frame_end;

    // A frame ends at the line end of its last line.
    always_comb frame_end = line_end && (vpos == frame_last);

    // Step the line count at each line end and restart it at a frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         vpos <= '0;
        else if (frame_end) vpos <= '0;
        else if (line_end)  vpos <= vpos + 1'b1;
    end

    // Toggle or clear the long-frame flag at a frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         long_frame <= 1'b0;
        else if (frame_end) long_frame <= interlace ? ~long_frame : 1'b0;
    end

endmodule

// File: rtl/beam_line_flag.sv
// Long-line flag: flips at each line end while alternation is active.
// Assumes alt_on is derived from registered control bits.
module beam_line_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_on,
    input  logic line_end,
    output logic long_line
);

    // Clear when alternation is off, else invert on each line end.
    always_ff @(posedge clk) begin
        if (!rst_n || !alt_on) long_line <= 1'b0;
        else if (line_end)     long_line <= ~long_line;
    end

endmodule

// File: rtl/beam_position_counter.sv
// Beam position counter: horizontal/vertical positions, long-line and long-frame
// flags, fixed 50/60 Hz totals or programmed totals, and a secondary horizontal
// counter that may drive the end-of-line comparator.
// Assumes totals are written while the beam is below them, and a total plus one
// must fit in its counter width.
module beam_position_counter
    import beam_pkg::*;
#(
    parameter int HW = 9,
    parameter int VW = 9,
    parameter int DW = 9,
    parameter int FIX_LINE_CLKS  = 227,
    parameter int FIX_PAL_LINES  = 312,
    parameter int FIX_NTSC_LINES = 262,
    parameter int RST_H2_LAST    = 226
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos,
    output logic [HW-1:0] hpos_alt,
    output logic          long_line,
    output logic          long_frame
);

    localparam logic [HW-1:0] FIX_H_LAST    = HW'(FIX_LINE_CLKS - 1);
    localparam logic [VW-1:0] FIX_PAL_LAST  = VW'(FIX_PAL_LINES - 1);
    localparam logic [VW-1:0] FIX_NTSC_LAST = VW'(FIX_NTSC_LINES - 1);

    beam_ctrl_t    ctrl;
    logic [HW-1:0] h_last_reg, h2_last_reg;
    logic [VW-1:0] v_last_reg;
    logic          alt_on;
    logic [HW-1:0] line_last, h_cmp;
    logic [VW-1:0] frame_last;
    logic          line_end, alt_wrap;

    beam_regs #(
        .HW(HW), .VW(VW), .DW(DW),
        .RST_H_LAST(FIX_LINE_CLKS - 1),
        .RST_V_LAST(FIX_NTSC_LINES - 1),
        .RST_H2_LAST(RST_H2_LAST)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .h_last_reg(h_last_reg),
        .v_last_reg(v_last_reg), .h2_last_reg(h2_last_reg)
    );

    // Alternation runs only with both the pal and no_alt bits clear.
    always_comb alt_on = !ctrl.pal && !ctrl.no_alt;

    // Select the line total, the compared position and the frame total.
    always_comb begin
        line_last  = (ctrl.prog ? h_last_reg : FIX_H_LAST) + HW'(long_line);
        h_cmp      = ctrl.dual ? hpos_alt : hpos;
        line_end   = (h_cmp == line_last);
        frame_last = (ctrl.prog ? v_last_reg
                                : (ctrl.pal ? FIX_PAL_LAST : FIX_NTSC_LAST))
                     + VW'(long_frame);
        alt_wrap   = (hpos_alt == h2_last_reg);
    end

    beam_wrap_counter #(.W(HW)) i_hcount (
        .clk(clk), .rst_n(rst_n), .wrap(line_end), .cnt(hpos)
    );

    beam_wrap_counter #(.W(HW)) i_hcount_alt (
        .clk(clk), .rst_n(rst_n), .wrap(alt_wrap), .cnt(hpos_alt)
    );

    beam_line_flag i_line_flag (
        .clk(clk), .rst_n(rst_n), .alt_on(alt_on),
        .line_end(line_end), .long_line(long_line)
    );

    beam_vertical #(.VW(VW)) i_vertical (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .frame_last(frame_last), .interlace(ctrl.interlace),
        .vpos(vpos), .long_frame(long_frame)
    );

endmodule

// File: rtl/beam_position_checker.sv
// Cycle-by-cycle stepping rules of the beam position counter.
// Assumes rst_n is low from time zero until the first clock edges.
module beam_position_checker #(
    parameter int HW = 9,
    parameter int VW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] hpos,
    input logic [VW-1:0] vpos,
    input logic [HW-1:0] hpos_alt,
    input logic          long_line,
    input logic          long_frame,
    input logic          alt_on
);

    a_r11_h_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos != '0) |-> (hpos == $past(hpos) + 1'b1));

    a_r11_v_moves_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        (vpos != $past(vpos)) |-> (hpos == '0));

    a_r11_v_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vpos != $past(vpos)) |-> (vpos == '0 || vpos == $past(vpos) + 1'b1));

    a_r9_alt_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos_alt != '0) |-> (hpos_alt == $past(hpos_alt) + 1'b1));

    a_r7_long_line_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_line) |-> (hpos == '0));

    a_r7_long_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(alt_on) |-> !long_line);

    a_r8_long_frame_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (long_frame != $past(long_frame)) |-> (hpos == '0 && vpos == '0));

endmodule

bind beam_position_counter beam_position_checker #(.HW(HW), .VW(VW)) i_checker (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .hpos_alt(hpos_alt),
    .long_line(long_line), .long_frame(long_frame), .alt_on(alt_on)
);

// File: tb/test_beam_position_counter.sv
// Self-checking bench: arithmetic per-cycle model plus measured line and frame lengths.
module test_beam_position_counter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [8:0] hpos, vpos, hpos_alt;
    logic       long_line, long_frame;

    beam_position_counter i_beam_position_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hpos(hpos), .vpos(vpos), .hpos_alt(hpos_alt),
        .long_line(long_line), .long_frame(long_frame)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state.
    int m_ctrl, m_hl, m_vl, m_h2l, m_h, m_v, m_h2, m_lol, m_lof;
    // Phase mismatch record.
    int ph_mis = 0;
    string f_sig;
    int f_act, f_exp;
    // Measurements taken at the ports.
    int since = 0, len_a = 0, len_b = 0;
    int prev_v = 0, vmax_a = 0, vmax_b = 0, h2max = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int pal, noalt, prog, dual, ilace, alt, hlast, vlast, hc, eol;
        int n_h, n_v, n_h2, n_lol, n_lof;
        if (!rst_n) begin
            m_ctrl = 0; m_hl = 226; m_vl = 261; m_h2l = 226;
            m_h = 0; m_v = 0; m_h2 = 0; m_lol = 0; m_lof = 0;
            return;
        end
        pal = m_ctrl & 1; noalt = (m_ctrl >> 1) & 1; prog = (m_ctrl >> 2) & 1;
        dual = (m_ctrl >> 3) & 1; ilace = (m_ctrl >> 4) & 1;
        alt = (pal == 0 && noalt == 0);
        hlast = (prog ? m_hl : 226) + m_lol;
        vlast = (prog ? m_vl : (pal ? 311 : 261)) + m_lof;
        hc = dual ? m_h2 : m_h;
        eol = (hc == hlast);
        n_h2 = (m_h2 == m_h2l) ? 0 : (m_h2 + 1) % 512;
        n_h = eol ? 0 : (m_h + 1) % 512;
        n_lol = !alt ? 0 : (eol ? 1 - m_lol : m_lol);
        n_v = eol ? ((m_v == vlast) ? 0 : (m_v + 1) % 512) : m_v;
        n_lof = (eol && m_v == vlast) ? (ilace ? 1 - m_lof : 0) : m_lof;
        m_h = n_h; m_v = n_v; m_h2 = n_h2; m_lol = n_lol; m_lof = n_lof;
        if (wr_en) begin
            case (wr_addr)
                2'd0: m_ctrl = int'(wr_data) & 31;
                2'd1: m_hl = int'(wr_data);
                2'd2: m_vl = int'(wr_data);
                default: m_h2l = int'(wr_data);
            endcase
        end
    endtask

    task automatic cmp(input string name, input int act, input int exp);
        if (act != exp) begin
            if (ph_mis == 0) begin f_sig = name; f_act = act; f_exp = exp; end
            ph_mis++;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp("hpos", int'(hpos), m_h);
        cmp("vpos", int'(vpos), m_v);
        cmp("hpos_alt", int'(hpos_alt), m_h2);
        cmp("long_line", int'(long_line), m_lol);
        cmp("long_frame", int'(long_frame), m_lof);
        if (hpos == 0) begin len_b = len_a; len_a = since; since = 1; end
        else since++;
        if (vpos == 0 && prev_v != 0) begin vmax_b = vmax_a; vmax_a = prev_v; end
        prev_v = int'(vpos);
        if (int'(hpos_alt) > h2max) h2max = int'(hpos_alt);
    endtask

    task automatic end_phase(input string tag);
        chk(ph_mis == 0, tag, {"per-cycle ", f_sig}, f_act, f_exp);
        ph_mis = 0;
    endtask

    task automatic run(input int n, input string tag);
        repeat (n) cyc();
        end_phase(tag);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 9'(data);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        chk(hpos == 0 && vpos == 0, "R1", "reset h/v", int'(hpos) + int'(vpos), 0);
        chk(hpos_alt == 0, "R1", "reset hpos_alt", int'(hpos_alt), 0);
        chk(!long_line && !long_frame, "R1", "reset flags",
            int'(long_line) + int'(long_frame), 0);
        end_phase("R1 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // Fixed 60 Hz: alternating 227/228 lines, 262-line frame.
        run(600, "R2 R7 R11 fixed60 start");
        chk(len_a + len_b == 455 && len_a != len_b, "R2", "line pair length",
            len_a + len_b, 455);
        chk(long_line == 1'b1 || long_line == 1'b0, "R7", "flag defined", 0, 0);
        run(59100, "R2 R11 fixed60 frame");
        chk(vmax_a == 261, "R2", "last line index", vmax_a, 261);
        // No-alternation bit.
        wr(0, 2);
        run(1000, "R4 R7 no_alt");
        chk(len_a == 227 && len_b == 227, "R4", "short lines", len_a + len_b, 454);
        chk(long_line == 1'b0, "R4", "long_line held", int'(long_line), 0);
        // Fixed 50 Hz.
        wr(0, 1);
        run(70500, "R3 R11 fixed50");
        chk(vmax_a == 311, "R3", "last line index", vmax_a, 311);
        chk(len_a == 227 && len_b == 227, "R3", "line length", len_a + len_b, 454);
        // Reset from a running state.
        do_reset();
        // Programmed totals with interlace.
        wr(1, 9); wr(2, 4); wr(3, 6); wr(0, 20);
        h2max = 0;
        run(400, "R5 R8 R9 R12 programmed");
        chk(len_a + len_b == 21 && len_a != len_b, "R5", "line pair length",
            len_a + len_b, 21);
        chk(vmax_a + vmax_b == 9 && vmax_a != vmax_b, "R8", "frame heights alternate",
            vmax_a + vmax_b, 9);
        chk(h2max == 6, "R9", "secondary peak", h2max, 6);
        // Programmed with pal: alternation stops, interlace off clears long_frame.
        wr(0, 5);
        run(300, "R6 R8 programmed pal");
        chk(len_a == 10 && len_b == 10, "R6", "line length", len_a + len_b, 20);
        chk(long_line == 1'b0, "R6", "long_line held", int'(long_line), 0);
        chk(vmax_a == 4 && vmax_b == 4, "R8", "frame height", vmax_a + vmax_b, 8);
        chk(long_frame == 1'b0, "R8", "long_frame cleared", int'(long_frame), 0);
        // Dual source: line end follows the secondary counter (period 7).
        wr(1, 5); wr(0, 13);
        run(300, "R10 dual");
        chk(len_a == 7 && len_b == 7, "R10", "line length from secondary",
            len_a + len_b, 14);
        // Sweep of small programmed totals and modes.
        for (int ht = 3; ht <= 8; ht++) begin
            for (int vt = 1; vt <= 3; vt++) begin
                for (int k = 0; k < 4; k++) begin
                    int cfg;
                    cfg = (k == 0) ? 4 : (k == 1) ? 20 : (k == 2) ? 6 : 21;
                    wr(1, ht); wr(2, vt); wr(3, ht + 2); wr(0, cfg);
                    run(150, "R5 R6 R7 R8 R9 R11 R12 sweep");
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule